// File: doc/BRIEF.md
# Dual-Buffer Serial Command Front End

This block is the serial slave interface of a page-organised storage device. The host frames each transaction with an active-low chip select. Inside a frame the host shifts in an 8-bit opcode, then a 24-bit header. Buffer opcodes go on to data bytes. All fields travel most significant bit first. The block holds two independent 264-byte staging buffers and serves byte-stream reads and writes to them. Both address pointers wrap from the last byte back to byte 0.

Commands that act on whole pages are not run here. The block decodes them, captures the 11-bit page number and the buffer they name, and passes them to a separate operation sequencer as a one-cycle strobe when chip select rises. At each chip-select fall, the idle level of the serial clock picks the clock mode, 0 or 3. In both modes input bits are sampled on rising clock edges and output bits change on falling edges. The serial output is enabled only while read data is being shifted out.

The block oversamples the serial pins with a fast system clock. Its states are:

- `ST_IDLE`: chip select is high.
- `ST_OPCODE`: the 8 opcode bits are shifted in.
- `ST_HEADER`: the 24 header bits are shifted in.
- `ST_DUMMY`: the 8 wait bits of a read are counted.
- `ST_RDATA`: read data is shifted out.
- `ST_WDATA`: write data is shifted in.
- `ST_PAGE_WAIT`: a page command is complete and waits for chip select to rise.
- `ST_IGNORE`: the frame is discarded.

The transitions are:

- A chip-select fall moves any state to `ST_OPCODE`.
- A chip-select rise moves any state to `ST_IDLE`.
- After the 8th opcode bit, `ST_OPCODE` moves to `ST_HEADER`, or to `ST_IGNORE` for an unknown or blocked opcode.
- After the 24th header bit, `ST_HEADER` moves to `ST_DUMMY`, `ST_WDATA` or `ST_PAGE_WAIT`, according to the opcode.
- After the 8th wait bit, `ST_DUMMY` moves to `ST_RDATA`.
- Any further rising clock edge moves `ST_PAGE_WAIT` to `ST_IGNORE`.

Top module: `sbuf_frontend`

## Requirements
- R1: After reset `spi_so_en` is 0, `cmd_stb` is 0 and `mode_is3` is 1.
- R2: At each chip-select fall `mode_is3` takes the idle SCK level: 1 means mode 3 and 0 means mode 0. In both modes input bits are taken on rising SCK edges and output bits change on falling edges.
- R3: A buffer write frame is structured as follows:
  - The opcode is 84h for buffer 0 or 87h for buffer 1.
  - It is followed by 24 header bits, of which the last 9 are the start byte address.
  - Every complete data byte that follows is stored MSB first at the next address.
  - Bytes are accepted until chip select rises.
- R4: A buffer read frame is structured as follows:
  - The opcode is 54h for buffer 0 or 56h for buffer 1.
  - It is followed by 24 header bits (last 9 are the start address) and then 8 wait bits.
  - The stored bytes are then output MSB first, starting at the falling edge after the last wait bit.
- R5: Read and write pointers step from byte 263 to byte 0. A start address above 263 is taken as the address minus 264.
- R6: A write frame that ends partway through a byte leaves that byte's location unchanged.
- R7: `spi_so_en` is 1 only during the read data phase. It returns to 0 within a few system clocks after chip select rises.
- R8: The page opcodes are 53h, 60h, 83h, 88h and 58h, which name buffer 0, and 55h, 61h, 86h, 89h and 59h, which name buffer 1.
  - A page frame of exactly 32 bits gives one `cmd_stb` pulse of one cycle after chip select rises.
  - The pulse carries `cmd_opcode`, `cmd_buf` and `cmd_page`, which is header bits 19..9 (the 5th to 15th header bits sent).
  - A page frame of any other length gives no pulse.
- R9: Any other opcode is ignored until the next chip-select fall. Such a frame writes nothing, gives no strobe and leaves `spi_so_en` at 0.
- R10: While `seq_busy` is 1, the following rules apply:
  - Buffer reads and writes naming `seq_buf` are ignored as in R9.
  - The other buffer is served normally.
  - Page opcodes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_so | output | 1 | Serial data to host |
| spi_so_en | output | 1 | Output enable for `spi_so`; 0 means high impedance |
| mode_is3 | output | 1 | Clock mode picked at the last chip-select fall |
| seq_busy | input | 1 | Sequencer is running a page operation |
| seq_buf | input | 1 | Buffer held by the running page operation |
| cmd_stb | output | 1 | One-cycle page command strobe |
| cmd_opcode | output | 8 | Page command opcode |
| cmd_buf | output | 1 | Buffer named by the page command |
| cmd_page | output | 11 | Page number of the page command |

## Verification
The assertions rely on several properties of the inputs:
- Chip-select edges and SCK edges never reach the synchronised domain in the same system cycle.
- Each SCK half period spans several system clocks.
- Chip select stays high for several clocks between frames.

Under these conditions, every sampled edge is seen exactly once and each chip-select rise gives at most one strobe. The stimulus holds SCK and chip select steady for eight system clocks around every edge. It also drives all pins on the falling system clock edge, so every interval is far longer than the synchroniser latency.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

    typedef enum logic [1:0] {
        K_NONE,
        K_BUF_RD,
        K_BUF_WR,
        K_PAGE
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     bsel;
    } op_dec_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_HEADER,
        ST_DUMMY,
        ST_RDATA,
        ST_WDATA,
        ST_PAGE_WAIT,
        ST_IGNORE
    } fe_state_e;

    function automatic op_dec_t decode_op(input logic [7:0] op);
        op_dec_t d;
        d.kind = K_NONE;
        d.bsel = 1'b0;
        case (op)
            8'h54: begin d.kind = K_BUF_RD; d.bsel = 1'b0; end
            8'h56: begin d.kind = K_BUF_RD; d.bsel = 1'b1; end
            8'h84: begin d.kind = K_BUF_WR; d.bsel = 1'b0; end
            8'h87: begin d.kind = K_BUF_WR; d.bsel = 1'b1; end
            8'h53, 8'h60, 8'h83, 8'h88, 8'h58: begin d.kind = K_PAGE; d.bsel = 1'b0; end
            8'h55, 8'h61, 8'h86, 8'h89, 8'h59: begin d.kind = K_PAGE; d.bsel = 1'b1; end
            default: begin d.kind = K_NONE; d.bsel = 1'b0; end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sbuf_sync.sv
module sbuf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sck_lvl,
    output logic mosi_lvl,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall,
    output logic cs_rise
);
    logic [STAGES:0] sck_p, cs_p, mosi_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p  <= '0;
            cs_p   <= '1;
            mosi_p <= '0;
        end else begin
            sck_p  <= {sck_p[STAGES-1:0], sck_i};
            cs_p   <= {cs_p[STAGES-1:0], cs_n_i};
            mosi_p <= {mosi_p[STAGES-1:0], mosi_i};
        end
    end

    assign sck_lvl  = sck_p[STAGES-1];
    assign mosi_lvl = mosi_p[STAGES-1];
    assign sck_rise = sck_p[STAGES-1] & ~sck_p[STAGES];
    assign sck_fall = ~sck_p[STAGES-1] & sck_p[STAGES];
    assign cs_fall  = ~cs_p[STAGES-1] & cs_p[STAGES];
    assign cs_rise  = cs_p[STAGES-1] & ~cs_p[STAGES];
endmodule

// File: rtl/sbuf_mem.sv
module sbuf_mem #(
    parameter int DEPTH  = 264,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sbuf_frontend.sv
module sbuf_frontend
    import sbuf_pkg::*;
#(
    parameter int BUF_BYTES   = 264,
    parameter int ADDR_W      = 9,
    parameter int PAGE_W      = 11,
    parameter int HDR_BITS    = 24,
    parameter int DUMMY_BITS  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_so,
    output logic              spi_so_en,
    output logic              mode_is3,
    input  logic              seq_busy,
    input  logic              seq_buf,
    output logic              cmd_stb,
    output logic [7:0]        cmd_opcode,
    output logic              cmd_buf,
    output logic [PAGE_W-1:0] cmd_page
);
    localparam int NUM_BUFS = 2;
    localparam int CNT_W    = $clog2(HDR_BITS);
    localparam logic [CNT_W-1:0] OP_LAST  = CNT_W'(7);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] DUM_LAST = CNT_W'(DUMMY_BITS - 1);
    localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(7);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(BUF_BYTES - 1);

    logic sck_lvl, mosi_lvl, sck_rise, sck_fall, cs_fall, cs_rise;

    sbuf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sck_i(spi_sck), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
        .sck_lvl(sck_lvl), .mosi_lvl(mosi_lvl),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_fall(cs_fall), .cs_rise(cs_rise)
    );

    fe_state_e state, state_n;
    logic [CNT_W-1:0]    cnt;
    logic [HDR_BITS-1:0] sh;
    logic [7:0]          op_q;
    op_dec_t             dec_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [PAGE_W-1:0]   page_q;
    logic [2:0]          rd_bit;
    logic                wr_en;
    logic [ADDR_W-1:0]   wr_addr;
    logic [7:0]          wr_data;
    logic                wr_buf;
    logic [7:0]          rd_data [NUM_BUFS];

    genvar g;
    generate
        for (g = 0; g < NUM_BUFS; g++) begin : g_buf
            sbuf_mem #(.DEPTH(BUF_BYTES), .ADDR_W(ADDR_W)) u_mem (
                .clk(clk),
                .we(wr_en && (wr_buf == g[0])),
                .waddr(wr_addr), .wdata(wr_data),
                .raddr(addr_q), .rdata(rd_data[g])
            );
        end
    endgenerate

    function automatic logic [ADDR_W-1:0] norm_addr(input logic [ADDR_W-1:0] a);
        return (a > LAST_ADDR) ? ADDR_W'(a - ADDR_W'(BUF_BYTES)) : a;
    endfunction

    function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
        return (a >= LAST_ADDR) ? '0 : ADDR_W'(a + 1'b1);
    endfunction

    logic [7:0]          op_full;
    op_dec_t             dec_now;
    logic                op_reject;
    logic [HDR_BITS-1:0] hdr_full;
    logic [7:0]          rd_byte;

    assign op_full  = {sh[6:0], mosi_lvl};
    assign dec_now  = decode_op(op_full);
    assign op_reject = (dec_now.kind == K_NONE)
                    || (seq_busy && dec_now.kind == K_PAGE)
                    || (seq_busy && dec_now.kind != K_PAGE && dec_now.bsel == seq_buf);
    assign hdr_full = {sh[HDR_BITS-2:0], mosi_lvl};
    assign rd_byte  = rd_data[dec_q.bsel];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next-state logic
    always_comb begin
        state_n = state;
        if (cs_rise) begin
            state_n = ST_IDLE;
        end else if (cs_fall) begin
            state_n = ST_OPCODE;
        end else if (sck_rise) begin
            unique case (state)
                ST_IDLE:   state_n = ST_IDLE;
                ST_OPCODE: if (cnt == OP_LAST)
                               state_n = op_reject ? ST_IGNORE : ST_HEADER;
                ST_HEADER: if (cnt == HDR_LAST) begin
                               unique case (dec_q.kind)
                                   K_BUF_RD: state_n = ST_DUMMY;
                                   K_BUF_WR: state_n = ST_WDATA;
                                   K_PAGE:   state_n = ST_PAGE_WAIT;
                                   K_NONE:   state_n = ST_IGNORE;
                               endcase
                           end
                ST_DUMMY:  if (cnt == DUM_LAST) state_n = ST_RDATA;
                ST_RDATA:  state_n = ST_RDATA;
                ST_WDATA:  state_n = ST_WDATA;
                ST_PAGE_WAIT: state_n = ST_IGNORE;
                ST_IGNORE: state_n = ST_IGNORE;
            endcase
        end
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0; sh <= '0; op_q <= '0; dec_q <= '0;
            addr_q <= '0; page_q <= '0; rd_bit <= '0;
            wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0; wr_buf <= 1'b0;
            spi_so <= 1'b0; spi_so_en <= 1'b0; mode_is3 <= 1'b1;
            cmd_stb <= 1'b0; cmd_opcode <= '0; cmd_buf <= 1'b0; cmd_page <= '0;
        end else begin
            wr_en   <= 1'b0;
            cmd_stb <= 1'b0;
            if (cs_rise) begin
                spi_so_en <= 1'b0;
                if (state == ST_PAGE_WAIT) begin
                    cmd_stb    <= 1'b1;
                    cmd_opcode <= op_q;
                    cmd_buf    <= dec_q.bsel;
                    cmd_page   <= page_q;
                end
            end else if (cs_fall) begin
                mode_is3  <= sck_lvl;
                cnt       <= '0;
                spi_so_en <= 1'b0;
            end else if (sck_rise) begin
                unique case (state)
                    ST_OPCODE: begin
                        sh  <= hdr_full;
                        cnt <= (cnt == OP_LAST) ? '0 : cnt + 1'b1;
                        if (cnt == OP_LAST) begin
                            op_q  <= op_full;
                            dec_q <= dec_now;
                        end
                    end
                    ST_HEADER: begin
                        sh  <= hdr_full;
                        cnt <= (cnt == HDR_LAST) ? '0 : cnt + 1'b1;
                        if (cnt == HDR_LAST) begin
                            addr_q <= norm_addr(hdr_full[ADDR_W-1:0]);
                            page_q <= hdr_full[ADDR_W +: PAGE_W];
                        end
                    end
                    ST_DUMMY: begin
                        cnt <= (cnt == DUM_LAST) ? '0 : cnt + 1'b1;
                        if (cnt == DUM_LAST) begin
                            spi_so_en <= 1'b1;
                            rd_bit    <= '0;
                        end
                    end
                    ST_WDATA: begin
                        sh  <= hdr_full;
                        cnt <= (cnt == BYTE_LAST) ? '0 : cnt + 1'b1;
                        if (cnt == BYTE_LAST) begin
                            wr_en   <= 1'b1;
                            wr_buf  <= dec_q.bsel;
                            wr_addr <= addr_q;
                            wr_data <= op_full;
                            addr_q  <= next_addr(addr_q);
                        end
                    end
                    ST_IDLE, ST_RDATA, ST_PAGE_WAIT, ST_IGNORE: ;
                endcase
            end else if (sck_fall && state == ST_RDATA) begin
                spi_so <= rd_byte[3'd7 - rd_bit];
                rd_bit <= rd_bit + 1'b1;
                if (rd_bit == 3'd7) addr_q <= next_addr(addr_q);
            end
        end
    end
endmodule

// File: rtl/sbuf_checker.sv
module sbuf_checker
    import sbuf_pkg::*;
#(
    parameter int BUF_BYTES = 264,
    parameter int ADDR_W    = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_rise,
    input logic              spi_so_en,
    input logic              cmd_stb,
    input logic [7:0]        cmd_opcode,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] addr_q
);
    assert_stb_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> !cmd_stb);

    assert_stb_page_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> (decode_op(cmd_opcode).kind == K_PAGE));

    assert_hiz_after_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !spi_so_en);

    assert_no_drive_with_stb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> !spi_so_en);

    assert_wr_addr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr < ADDR_W'(BUF_BYTES)));

    assert_rd_addr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_so_en |-> (addr_q < ADDR_W'(BUF_BYTES)));
endmodule

bind sbuf_frontend sbuf_checker #(.BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .spi_so_en(spi_so_en),
    .cmd_stb(cmd_stb), .cmd_opcode(cmd_opcode), .wr_en(wr_en),
    .wr_addr(wr_addr), .addr_q(addr_q)
);

// File: tb/sbuf_frontend_tb.sv
module sbuf_frontend_tb;
    logic clk = 0, rst_n = 0;
    logic sck = 0, cs_n = 1, mosi = 0;
    logic seq_busy = 0, seq_buf = 0;
    logic so, so_en, mode_is3, cmd_stb, cmd_buf;
    logic [7:0] cmd_opcode;
    logic [10:0] cmd_page;

    int n_chk = 0, n_bad = 0, stb_cnt = 0;
    logic [7:0] stb_op; logic stb_buf; logic [10:0] stb_page;
    logic cur_mode3 = 0;
    logic so_seen = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sbuf_frontend u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_so(so), .spi_so_en(so_en), .mode_is3(mode_is3),
        .seq_busy(seq_busy), .seq_buf(seq_buf), .cmd_stb(cmd_stb),
        .cmd_opcode(cmd_opcode), .cmd_buf(cmd_buf), .cmd_page(cmd_page)
    );

    always @(negedge clk) begin
        if (cmd_stb) begin
            stb_cnt++; stb_op = cmd_opcode; stb_buf = cmd_buf; stb_page = cmd_page;
        end
        if (so_en) so_seen = 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_begin(input logic m3);
        cur_mode3 = m3; sck = m3; waitc(8);
        cs_n = 0; so_seen = 0; waitc(8);
    endtask

    task automatic cs_end();
        waitc(8); cs_n = 1; waitc(12);
    endtask

    task automatic bit_x(input logic b, output logic r);
        mosi = b;
        if (cur_mode3) begin
            sck = 0; waitc(8); r = so; sck = 1; waitc(8);
        end else begin
            waitc(8); r = so; sck = 1; waitc(8); sck = 0;
        end
    endtask

    task automatic xbyte(input logic [7:0] d, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) bit_x(d[i], r[i]);
    endtask

    task automatic send(input logic [7:0] d);
        logic [7:0] r; xbyte(d, r);
    endtask

    task automatic send_hdr(input logic [23:0] h);
        send(h[23:16]); send(h[15:8]); send(h[7:0]);
    endtask

    task automatic buf_write(input logic m3, input logic [7:0] op, input int addr,
                             input logic [7:0] d [], input int extra_bits);
        logic r;
        cs_begin(m3);
        send(op); send_hdr(24'(addr));
        foreach (d[i]) send(d[i]);
        for (int i = 0; i < extra_bits; i++) bit_x(1'b0, r);
        cs_end();
    endtask

    task automatic buf_read(input logic m3, input logic [7:0] op, input int addr,
                            input int n, output logic [7:0] q []);
        cs_begin(m3);
        send(op); send_hdr(24'(addr)); send(8'h00);
        q = new[n];
        for (int i = 0; i < n; i++) xbyte(8'h00, q[i]);
        cs_end();
    endtask

    task automatic page_cmd(input logic [7:0] op, input logic [10:0] pg, input int nbits);
        logic [31:0] w; logic r;
        w = {op, 4'b0, pg, 9'h1A5};
        cs_begin(0);
        for (int i = 0; i < nbits; i++) bit_x(i < 32 ? w[31-i] : 1'b1, r);
        cs_end();
    endtask

    task automatic t_reset();
        check(so_en == 0, "R1 so_en", so_en, 0);
        check(cmd_stb == 0, "R1 cmd_stb", cmd_stb, 0);
        check(mode_is3 == 1, "R1 mode_is3", mode_is3, 1);
    endtask

    task automatic t_write_read_mode0();
        logic [7:0] d [] = '{8'hA5, 8'h3C, 8'hF0, 8'h01};
        logic [7:0] q [];
        buf_write(0, 8'h84, 10, d, 0);
        check(mode_is3 == 0, "R2 mode0", mode_is3, 0);
        buf_read(0, 8'h54, 10, 4, q);
        for (int i = 0; i < 4; i++) check(q[i] == d[i], "R3 R4 buf0 data", q[i], d[i]);
        check(so_seen == 1, "R7 so_en during read", so_seen, 1);
        check(so_en == 0, "R7 hiz after cs", so_en, 0);
    endtask

    task automatic t_mode3_buf1();
        logic [7:0] d [] = '{8'h5A, 8'hC3};
        logic [7:0] q [];
        buf_write(1, 8'h87, 10, d, 0);
        check(mode_is3 == 1, "R2 mode3", mode_is3, 1);
        buf_read(1, 8'h56, 10, 2, q);
        check(q[0] == 8'h5A && q[1] == 8'hC3, "R2 R4 buf1 mode3 read", {q[0], q[1]}, 16'h5AC3);
        buf_read(0, 8'h54, 10, 1, q);
        check(q[0] == 8'hA5, "R3 buf0 untouched", q[0], 8'hA5);
    endtask

    task automatic t_wrap();
        logic [7:0] d [] = '{8'h11, 8'h22, 8'h33, 8'h44};
        logic [7:0] q [];
        buf_write(0, 8'h84, 262, d, 0);
        buf_read(0, 8'h54, 0, 2, q);
        check(q[0] == 8'h33 && q[1] == 8'h44, "R5 write wrap", {q[0], q[1]}, 16'h3344);
        buf_read(1, 8'h54, 262, 4, q);
        check({q[0], q[1], q[2], q[3]} == 32'h11223344, "R5 read wrap",
              {q[0], q[1], q[2], q[3]}, 32'h11223344);
        buf_write(0, 8'h84, 300, '{8'h9E}, 0);
        buf_read(0, 8'h54, 36, 1, q);
        check(q[0] == 8'h9E, "R5 start above 263", q[0], 8'h9E);
    endtask

    task automatic t_partial();
        logic [7:0] q [];
        buf_write(0, 8'h84, 50, '{8'h77, 8'h88}, 0);
        buf_write(0, 8'h84, 50, '{8'h12}, 5);
        buf_read(0, 8'h54, 50, 2, q);
        check(q[0] == 8'h12, "R6 full byte kept", q[0], 8'h12);
        check(q[1] == 8'h88, "R6 partial discarded", q[1], 8'h88);
    endtask

    task automatic t_page();
        int c0;
        c0 = stb_cnt;
        page_cmd(8'h86, 11'h5B3, 32);
        check(stb_cnt == c0 + 1, "R8 strobe count", stb_cnt - c0, 1);
        check(stb_op == 8'h86 && stb_buf == 1 && stb_page == 11'h5B3, "R8 strobe fields",
              {stb_op, 3'b0, stb_buf, 5'b0, stb_page}, {8'h86, 4'h1, 16'h05B3});
        page_cmd(8'h53, 11'h002, 32);
        check(stb_op == 8'h53 && stb_buf == 0 && stb_page == 11'h002, "R8 buf0 page",
              {stb_op, 5'b0, stb_page}, {8'h53, 16'h0002});
        c0 = stb_cnt;
        page_cmd(8'h60, 11'h010, 33);
        page_cmd(8'h60, 11'h010, 31);
        check(stb_cnt == c0, "R8 wrong length no strobe", stb_cnt - c0, 0);
    endtask

    task automatic t_unknown();
        int c0;
        logic [7:0] q [];
        c0 = stb_cnt;
        cs_begin(0);
        send(8'h57); send_hdr(24'd10); send(8'h00); send(8'hFF); send(8'hFF);
        check(so_seen == 0, "R9 no drive", so_seen, 0);
        cs_end();
        cs_begin(0);
        send(8'h85); send_hdr(24'd10); send(8'hEE);
        cs_end();
        check(stb_cnt == c0, "R9 no strobe", stb_cnt - c0, 0);
        buf_read(0, 8'h54, 10, 1, q);
        check(q[0] == 8'hA5, "R9 no write", q[0], 8'hA5);
    endtask

    task automatic t_busy();
        int c0;
        logic [7:0] q [];
        seq_busy = 1; seq_buf = 0;
        c0 = stb_cnt;
        buf_write(0, 8'h84, 10, '{8'h00}, 0);
        buf_write(0, 8'h87, 20, '{8'hB7}, 0);
        buf_read(0, 8'h54, 10, 1, q);
        check(so_seen == 0, "R10 blocked read hiz", so_seen, 0);
        buf_read(0, 8'h56, 20, 1, q);
        check(q[0] == 8'hB7, "R10 other buffer served", q[0], 8'hB7);
        page_cmd(8'h55, 11'h100, 32);
        check(stb_cnt == c0, "R10 page ignored", stb_cnt - c0, 0);
        seq_busy = 0;
        buf_read(0, 8'h54, 10, 1, q);
        check(q[0] == 8'hA5, "R10 blocked write ignored", q[0], 8'hA5);
    endtask

    initial begin
        waitc(5);
        rst_n = 1;
        waitc(5);
        t_reset();
        t_write_read_mode0();
        t_mode3_buf1();
        t_wrap();
        t_partial();
        t_page();
        t_unknown();
        t_busy();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule